// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-facing register front end of a floppy disk controller. A byte-wide host bus reaches three registers: a control register that selects a drive, turns motors on, enables the interrupt line and holds the controller in reset; a status register that paces all traffic; and a data port. Through the data port the host writes a command byte and its parameters. The block then runs the command and hands back the result bytes.

No media is modelled. Each drive has a present-cylinder register that stands for its head position. Seek and recalibrate update this register after a programmable busy time and then post an interrupt. Read and write commands stay busy for the same time and then report a normal termination. The host drives the block by polling the status register and moving one byte at a time when the handshake bits allow it.

Top module: `fdc_cmd_seq`

## Requirements
- R1: After `rst_n` the control register reads 0x00. This holds the controller in reset: the status register reads 0x00 and data-port writes are dropped. Writing control bit 2 = 1 brings the controller up idle, with status 0x80.
- R2: The status register layout is: bit 7 ready for a data-port transfer, bit 6 next transfer is controller-to-host, bit 4 a command is in progress, bit n (n = 0..3) drive n is seeking or recalibrating, and bit 5 always 0.
- R3: A data-port write is taken only while status bits 7:6 = 10, and any other write has no effect. A data-port read outside the result phase returns 0x00 and changes nothing.
- R4: Only opcode bits 4:0 are decoded, so bits 7:5 are ignored. Parameter/result byte counts are: 0x03 2/0, 0x07 1/0, 0x0F 2/0, 0x08 0/2, 0x10 0/1, 0x04 1/1, 0x06 and 0x05 8/7.
- R5: Opcode 0x10 returns the single byte 0x90. Any opcode outside R4 goes straight to the result phase and returns the single byte 0x80.
- R6: Seek takes two bytes: a drive byte (bits 1:0 = drive) and a target cylinder. It is busy for exactly EXEC_CYCLES cycles with status 0x10 plus the drive's busy bit. Then that drive's present cylinder becomes the target and an interrupt is pending.
- R7: Recalibrate takes a drive byte and behaves like a seek to cylinder 0.
- R8: Sense interrupt (0x08) with an interrupt pending returns ST0 = 0x20 | drive, then that drive's present cylinder. The pending flag clears when the second byte is read. With nothing pending it returns the single byte 0x80.
- R9: `irq` is high exactly when an interrupt is pending and control bit 3 is 1.
- R10: Read (0x06) and write (0x05) take eight bytes: drive byte (bit 2 head, bits 1:0 drive), C, H, R, N, EOT, GAP, DTL. Status reads 0x10 for exactly EXEC_CYCLES cycles. The result is ST0 = drive byte bits 2:0, ST1 = 0, ST2 = 0, then C, H, R, N. No interrupt is raised.
- R11: Sense drive status (0x04) with a drive byte returns one byte: bit 5 = 1, bit 4 = present cylinder of that drive is 0, bit 2 = head, bits 1:0 = drive.
- R12: Reading the last result byte returns status to 0x80. A command with no result returns to 0x80 straight after its last parameter or execution.
- R13: Control bits 1:0 drive `drv_sel` and bits 7:4 drive `motor_on`. Clearing bit 2 aborts any command, clears the pending interrupt and sets every present cylinder to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data port |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| rd_en | input | 1 | Host read strobe; a data-port read consumes a result byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| drv_sel | output | 2 | Selected drive from the control register |
| motor_on | output | 4 | Motor enables, one per drive |

## Verification
The hardest state to reach is a write arriving while the block is executing, paired with an interrupt whose visibility depends on a later change to the control register. The stimulus starts a seek and issues a command byte during the busy window. It then confirms that the block comes back idle rather than in a result phase. A second seek runs with the interrupt enable cleared: `irq` stays low until the enable is set afterwards. A third pending interrupt is then wiped by pulsing the controller reset bit. The bench times each execution phase by counting idle-to-ready polls of the status register against EXEC_CYCLES.

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq #(
  parameter int EXEC_CYCLES = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq,
  output logic [1:0] drv_sel,
  output logic [3:0] motor_on
);
  localparam int CW = $clog2(EXEC_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(EXEC_CYCLES - 1);
  localparam logic [4:0] OP_SPEC = 5'h03, OP_RECAL = 5'h07, OP_SEEK = 5'h0F,
                         OP_SINT = 5'h08, OP_VER = 5'h10, OP_SDRV = 5'h04,
                         OP_READ = 5'h06, OP_WRITE = 5'h05, OP_BAD = 5'h00;

  typedef enum logic [1:0] {PH_CMD, PH_PARAM, PH_EXEC, PH_RESULT} phase_t;

  logic [7:0]    ctl_q;
  phase_t        phase;
  logic [4:0]    op_q;
  logic [2:0]    unit_q;
  logic [7:0]    arg [0:3];
  logic [2:0]    pidx, ridx;
  logic [CW-1:0] cnt;
  logic [7:0]    pcn [0:3];
  logic          int_pend;
  logic [1:0]    int_drv;

  function automatic logic [3:0] n_par(input logic [4:0] op);
    case (op)
      OP_SPEC, OP_SEEK:   n_par = 4'd2;
      OP_RECAL, OP_SDRV:  n_par = 4'd1;
      OP_READ, OP_WRITE:  n_par = 4'd8;
      default:            n_par = 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] n_res(input logic [4:0] op);
    case (op)
      OP_SINT:                     n_res = 4'd2;
      OP_READ, OP_WRITE:           n_res = 4'd7;
      OP_SPEC, OP_RECAL, OP_SEEK:  n_res = 4'd0;
      default:                     n_res = 4'd1;
    endcase
  endfunction

  wire ctl_run   = ctl_q[2];
  wire rqm       = ctl_run && phase != PH_EXEC;
  wire dio       = phase == PH_RESULT;
  wire busy      = phase != PH_CMD;
  wire wr_port   = wr_en && reg_sel == 2'd2 && ctl_run;
  wire rd_port   = rd_en && reg_sel == 2'd2 && ctl_run;
  wire accept_wr = wr_port && rqm && !dio;
  wire accept_rd = rd_port && phase == PH_RESULT;
  wire last_par  = ({1'b0, pidx} + 4'd1) == n_par(op_q);
  wire last_res  = ({1'b0, ridx} + 4'd1) == n_res(op_q);
  wire seek_op   = op_q == OP_SEEK || op_q == OP_RECAL;
  wire ctl_wr    = wr_en && reg_sel == 2'd0;

  wire [3:0] seek_busy = (phase == PH_EXEC && seek_op) ? (4'b0001 << unit_q[1:0]) : 4'b0000;
  wire [7:0] status    = ctl_run ? {rqm, dio, 1'b0, busy, seek_busy} : 8'h00;

  logic [7:0] res_byte;
  always_comb begin
    case (op_q)
      OP_SINT:  res_byte = (ridx == 3'd0) ? {6'b001000, int_drv} : pcn[int_drv];
      OP_VER:   res_byte = 8'h90;
      OP_SDRV:  res_byte = {2'b00, 1'b1, pcn[unit_q[1:0]] == 8'h00, 1'b0, unit_q};
      OP_READ, OP_WRITE:
        case (ridx)
          3'd0:    res_byte = {5'b00000, unit_q};
          3'd3:    res_byte = arg[0];
          3'd4:    res_byte = arg[1];
          3'd5:    res_byte = arg[2];
          3'd6:    res_byte = arg[3];
          default: res_byte = 8'h00;
        endcase
      default:  res_byte = 8'h80;
    endcase
  end

  always_comb begin
    case (reg_sel)
      2'd0:    rdata = ctl_q;
      2'd1:    rdata = status;
      2'd2:    rdata = (ctl_run && phase == PH_RESULT) ? res_byte : 8'h00;
      default: rdata = 8'h00;
    endcase
  end

  assign irq      = int_pend && ctl_q[3];
  assign drv_sel  = ctl_q[1:0];
  assign motor_on = ctl_q[7:4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= 8'h00;
      phase    <= PH_CMD;
      op_q     <= OP_BAD;
      unit_q   <= 3'd0;
      pidx     <= 3'd0;
      ridx     <= 3'd0;
      cnt      <= '0;
      int_pend <= 1'b0;
      int_drv  <= 2'd0;
      for (int i = 0; i < 4; i++) begin
        arg[i] <= 8'h00;
        pcn[i] <= 8'h00;
      end
    end else begin
      if (ctl_wr) ctl_q <= wdata;
      if (!ctl_run) begin
        phase    <= PH_CMD;
        int_pend <= 1'b0;
        pidx     <= 3'd0;
        ridx     <= 3'd0;
        cnt      <= '0;
        for (int i = 0; i < 4; i++) pcn[i] <= 8'h00;
      end else begin
        case (phase)
          PH_CMD: if (accept_wr) begin
            op_q <= (wdata[4:0] == OP_SINT && !int_pend) ? OP_BAD : wdata[4:0];
            pidx <= 3'd0;
            ridx <= 3'd0;
            phase <= (n_par(wdata[4:0]) != 4'd0) ? PH_PARAM : PH_RESULT;
          end
          PH_PARAM: if (accept_wr) begin
            if (pidx == 3'd0) unit_q <= wdata[2:0];
            else if (pidx <= 3'd4) arg[pidx[1:0] - 2'd1] <= wdata;
            if (last_par) begin
              cnt <= '0;
              case (op_q)
                OP_SPEC: phase <= PH_CMD;
                OP_SDRV: phase <= PH_RESULT;
                default: phase <= PH_EXEC;
              endcase
            end else begin
              pidx <= pidx + 3'd1;
            end
          end
          PH_EXEC: if (cnt == CNT_LAST) begin
            if (seek_op) begin
              phase             <= PH_CMD;
              pcn[unit_q[1:0]]  <= (op_q == OP_SEEK) ? arg[0] : 8'h00;
              int_pend          <= 1'b1;
              int_drv           <= unit_q[1:0];
            end else begin
              phase <= PH_RESULT;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
          PH_RESULT: if (accept_rd) begin
            if (last_res) begin
              phase <= PH_CMD;
              if (op_q == OP_SINT) int_pend <= 1'b0;
            end else begin
              ridx <= ridx + 3'd1;
            end
          end
          default: phase <= PH_CMD;
        endcase
      end
    end
  end

  a_r6_exec_hold: assert property (@(posedge clk) disable iff (!rst_n || !ctl_run)
    (phase == PH_EXEC && cnt != CNT_LAST && !ctl_wr) |=> phase == PH_EXEC);

  a_r6_seek_lands: assert property (@(posedge clk) disable iff (!rst_n || !ctl_run)
    (phase == PH_EXEC && op_q == OP_SEEK && cnt == CNT_LAST && !ctl_wr)
      |=> (pcn[$past(unit_q[1:0])] == $past(arg[0]) && int_pend));

  a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n || !ctl_run)
    (wr_port && phase == PH_RESULT && !rd_en && !ctl_wr) |=> (phase == PH_RESULT && $stable(ridx)));

  a_r12_last_byte_idle: assert property (@(posedge clk) disable iff (!rst_n || !ctl_run)
    (accept_rd && last_res) |=> phase == PH_CMD);

  a_r8_pend_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_pend) |-> $past(phase) == PH_EXEC);
endmodule

// File: tb/tb_fdc_cmd_seq.sv
`timescale 1ns/1ps
module tb_fdc_cmd_seq;
  localparam int EC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] drv_sel;
  logic [3:0] motor_on;

  int tests = 0;
  int fails = 0;
  logic mon_off = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  fdc_cmd_seq #(.EXEC_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .drv_sel(drv_sel), .motor_on(motor_on));

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rd_en && reg_sel == 2'd2 && !mon_off) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected result read: actual 0x%0h expected none", rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s result byte: actual 0x%0h expected 0x%0h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; reg_sel = 2'd1;
  endtask

  task automatic rd_port();
    @(negedge clk);
    reg_sel = 2'd2; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; reg_sel = 2'd1;
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
    rd_port();
  endtask

  task automatic peek(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = rdata;
  endtask

  task automatic wait_exec(output int n, output logic [7:0] first);
    logic [7:0] st;
    n = 0;
    #1 st = rdata;
    first = st;
    while (!st[7] && n < 5000) begin
      n++;
      @(negedge clk);
      #1 st = rdata;
    end
  endtask

  logic [7:0] v;
  int n;

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    peek(2'd0, v); check("R1 control reg after reset", v, 8'h00);
    peek(2'd1, v); check("R1 status in reset", v, 8'h00);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h0C);
    peek(2'd1, v); check("R1 idle after release, write in reset dropped", v, 8'h80);

    wr(2'd2, 8'h10);
    peek(2'd1, v); check("R2 status in result phase", v, 8'hD0);
    expect_byte(8'h90, "R5 version");
    peek(2'd1, v); check("R12 idle after last byte", v, 8'h80);

    wr(2'd2, 8'h1F);
    expect_byte(8'h80, "R5 invalid opcode");
    peek(2'd1, v); check("R5 idle after invalid", v, 8'h80);

    peek(2'd2, v); check("R3 data read when idle", v, 8'h00);
    mon_off = 1'b1; rd_port(); mon_off = 1'b0;
    peek(2'd1, v); check("R3 idle read changes nothing", v, 8'h80);

    wr(2'd2, 8'h08);
    expect_byte(8'h80, "R8 sense int with nothing pending");

    wr(2'd2, 8'h0F);
    peek(2'd1, v); check("R2 status in parameter phase", v, 8'h90);
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h2A);
    wait_exec(n, v);
    check("R6 seek busy status", v, 8'h12);
    check("R6 seek busy length", n, EC);
    check("R9 irq after seek", irq, 1);
    wr(2'd2, 8'h08);
    expect_byte(8'h21, "R8 ST0");
    expect_byte(8'h2A, "R8 present cylinder");
    check("R8 irq cleared", irq, 0);

    wr(2'd2, 8'h04); wr(2'd2, 8'h05);
    expect_byte(8'h25, "R11 sense drive off track 0");
    wr(2'd2, 8'h04); wr(2'd2, 8'h00);
    expect_byte(8'h30, "R11 sense drive on track 0");

    wr(2'd2, 8'h07); wr(2'd2, 8'h01);
    wait_exec(n, v);
    check("R7 recal busy status", v, 8'h12);
    check("R7 recal busy length", n, EC);
    wr(2'd2, 8'h08);
    expect_byte(8'h21, "R7 ST0");
    expect_byte(8'h00, "R7 cylinder zero");
    wr(2'd2, 8'h04); wr(2'd2, 8'h01);
    expect_byte(8'h31, "R7 track 0 after recal");

    wr(2'd2, 8'h0F); wr(2'd2, 8'h02); wr(2'd2, 8'h09);
    wr(2'd2, 8'h10);
    wait_exec(n, v);
    peek(2'd1, v); check("R3 write during exec ignored", v, 8'h80);
    wr(2'd2, 8'h08);
    expect_byte(8'h22, "R6 ST0 drive 2");
    expect_byte(8'h09, "R6 cylinder drive 2");

    wr(2'd2, 8'hE6);
    wr(2'd2, 8'h06); wr(2'd2, 8'h03); wr(2'd2, 8'h01); wr(2'd2, 8'h05);
    wr(2'd2, 8'h02); wr(2'd2, 8'h12); wr(2'd2, 8'h1B); wr(2'd2, 8'hFF);
    wait_exec(n, v);
    check("R10 read busy status", v, 8'h10);
    check("R10 read busy length", n, EC);
    peek(2'd1, v); check("R4 upper opcode bits ignored", v, 8'hD0);
    expect_byte(8'h06, "R10 ST0");
    expect_byte(8'h00, "R10 ST1");
    expect_byte(8'h00, "R10 ST2");
    expect_byte(8'h03, "R10 C");
    expect_byte(8'h01, "R10 H");
    expect_byte(8'h05, "R10 R");
    expect_byte(8'h02, "R10 N");
    check("R10 no irq", irq, 0);

    wr(2'd2, 8'hC5);
    wr(2'd2, 8'h00); wr(2'd2, 8'h07); wr(2'd2, 8'h00); wr(2'd2, 8'h09);
    wr(2'd2, 8'h02); wr(2'd2, 8'h12); wr(2'd2, 8'h1B); wr(2'd2, 8'hFF);
    wait_exec(n, v);
    check("R10 write busy length", n, EC);
    expect_byte(8'h00, "R10 write ST0");
    expect_byte(8'h00, "R10 write ST1");
    expect_byte(8'h00, "R10 write ST2");
    expect_byte(8'h07, "R10 write C");
    expect_byte(8'h00, "R10 write H");
    expect_byte(8'h09, "R10 write R");
    expect_byte(8'h02, "R10 write N");

    wr(2'd2, 8'h03); wr(2'd2, 8'hDF); wr(2'd2, 8'h02);
    peek(2'd1, v); check("R12 specify has no result", v, 8'h80);
    check("R4 specify count", v, 8'h80);

    wr(2'd0, 8'h04);
    wr(2'd2, 8'h0F); wr(2'd2, 8'h03); wr(2'd2, 8'h07);
    wait_exec(n, v);
    check("R9 irq masked", irq, 0);
    wr(2'd0, 8'h0C);
    check("R9 irq unmasked", irq, 1);
    wr(2'd2, 8'h08);
    expect_byte(8'h23, "R8 ST0 drive 3");
    expect_byte(8'h07, "R8 cylinder drive 3");

    wr(2'd2, 8'h0F); wr(2'd2, 8'h00); wr(2'd2, 8'h05);
    wait_exec(n, v);
    wr(2'd0, 8'h08);
    peek(2'd1, v); check("R13 status held in reset", v, 8'h00);
    wr(2'd0, 8'h2E);
    check("R13 drive select", drv_sel, 2);
    check("R13 motor bits", motor_on, 4'h2);
    check("R13 pending cleared", irq, 0);
    peek(2'd1, v); check("R13 idle after reset pulse", v, 8'h80);
    wr(2'd2, 8'h08);
    expect_byte(8'h80, "R13 nothing pending");
    wr(2'd2, 8'h04); wr(2'd2, 8'h03);
    expect_byte(8'h33, "R13 cylinder cleared");

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule